// File: doc/BRIEF.md
# Drive-0 Reset and Diagnostic Handshake Sequencer

This sequencer lives in the first drive of a two-drive chain. A reset pulse (hardware or soft) or an execute-diagnostic command starts a sequence. During the sequence the block watches two shared open-collector lines that drive 1 pulls low: a presence line (`dasp_n_in`) and a pass line (`pdiag_n_in`). From them it learns whether drive 1 is fitted and whether drive 1 passed its self-test. It then merges that verdict with drive 0's own self-test code into one diagnostic code for the error register, clears BUSY and pulses an interrupt request.

Each window is counted in ticks of a prescaler that divides the clock by `TICK_DIV`, so hardware timescales (milliseconds to tens of seconds) and short simulation values both come from parameters. Both shared lines first pass through a two-flop synchronizer. Presence is learned only in a reset sequence. A diagnostic command reuses the presence found by the last reset.

States:

| State | Meaning |
|---|---|
| `ST_IDLE` | Not busy. |
| `ST_PRESENCE` | Waits for the presence line. |
| `ST_HOLDOFF` | Ignores the pass line while drive 1 releases it. |
| `ST_PASSWAIT` | Waits for the pass line. |
| `ST_SELFWAIT` | Waits for drive 0's own result. |
| `ST_POST` | One cycle that posts the code and raises the interrupt. |

Transitions:

- A reset pulse goes from any state to PRESENCE.
- IDLE goes to HOLDOFF on a command when drive 1 is present, and to SELFWAIT on a command when it is absent.
- PRESENCE goes to HOLDOFF when the presence line is seen, and to SELFWAIT when the presence window expires.
- HOLDOFF goes to PASSWAIT when the hold-off window expires.
- PASSWAIT goes to SELFWAIT when the pass line is seen. It also goes to SELFWAIT, recording a failure, when its window expires.
- SELFWAIT goes to POST once the own result has been latched.
- POST goes to IDLE.

Top module: `d0dg_seq`

## Requirements
- R1: After `rst_n` the block is idle: `busy`=0, `irq`=0, `err_code`=00h, `d1_present`=0.
- R2: A `restart_pls` cycle makes `busy` 1 on the next cycle from any state. It aborts any sequence in progress and forgets drive 1's presence and verdict.
- R3: In a reset sequence, `dasp_n_in` low before `PRES_TICKS` ticks sets `d1_present`=1. Otherwise `d1_present`=0, and completion comes no earlier than the expiry of that window.
- R4: With drive 1 absent, the pass line is not waited for and bit 7 of `err_code` is 0. A command sequence with drive 1 absent completes within a few cycles of the own result.
- R5: With drive 1 present, `pdiag_n_in` low after the `RELEASE_TICKS` hold-off and inside the pass window leaves bit 7 of `err_code` at 0.
- R6: With drive 1 present and no pass inside the window, bit 7 of `err_code` is 1, which is 80h ORed onto the own code. The window is `RST_PASS_TICKS` after a reset and `CMD_PASS_TICKS` after a command, counted after the hold-off.
- R7: `diag_cmd_pls` starts a sequence only from idle, reusing the presence learned at the last reset. While `busy` it is ignored.
- R8: `err_code[6:0]` equals the `self_code[6:0]` latched at a `self_done` cycle during the sequence (01h none, 02h formatter, 03h buffer, 04h ECC, 05h controller). Completion waits for that result.
- R9: On completion `busy` is 0 and `irq` is high for exactly one cycle, in the same cycle that `err_code` takes its new value. `err_code` holds until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| restart_pls | input | 1 | One-cycle hardware/soft reset request |
| diag_cmd_pls | input | 1 | One-cycle execute-diagnostic command |
| self_done | input | 1 | One-cycle strobe: drive 0 self-test finished |
| self_code | input | 8 | Drive 0 own diagnostic code, valid with `self_done` |
| dasp_n_in | input | 1 | Shared presence line, active low, asynchronous |
| pdiag_n_in | input | 1 | Shared pass line, active low, asynchronous |
| err_code | output | 8 | Merged diagnostic code for the error register |
| busy | output | 1 | BUSY flag |
| irq | output | 1 | One-cycle interrupt request at completion |
| d1_present | output | 1 | Drive 1 detected at the last reset |

## Verification
The bench goes after the window edges by measuring when completion arrives.

- A design with too short a presence or pass window finishes before the bound.
- A design that waits for the pass line with drive 1 absent finishes far too late.
- A design that honours a command in mid-sequence skips the presence watch and reports drive 1 missing.
- A design where a restart fails to abort keeps the stale presence and the failure flag.
- A design that mixes the two pass windows completes outside the band for one of the two kinds of sequence.

Random sequences mix all of these with random own codes and result timing.

// File: rtl/d0dg_pkg.sv
package d0dg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRESENCE,
        ST_HOLDOFF,
        ST_PASSWAIT,
        ST_SELFWAIT,
        ST_POST
    } d0dg_state_e;

    // Top bit carries the drive-1 failure flag, lower bits the own code.
    function automatic logic [7:0] merge_code(input logic d1_fail, input logic [7:0] own);
        return {d1_fail, own[6:0]};
    endfunction

endpackage

// File: rtl/d0dg_sync.sv
module d0dg_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1, stage2;

    // Lines idle high (released), so reset to ones.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '1;
            stage2 <= '1;
        end else begin
            stage1 <= async_in;
            stage2 <= stage1;
        end
    end

    assign sync_out = stage2;
endmodule

// File: rtl/d0dg_win_timer.sv
module d0dg_win_timer #(
    parameter int TICK_DIV = 4,
    parameter int CNT_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    output logic [CNT_W-1:0] ticks
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0]    PLAST = PW'(TICK_DIV - 1);
    localparam logic [CNT_W-1:0] TMAX  = '1;

    logic [PW-1:0] presc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc <= '0;
            ticks <= '0;
        end else if (clear) begin
            presc <= '0;
            ticks <= '0;
        end else if (presc == PLAST) begin
            presc <= '0;
            if (ticks != TMAX) ticks <= ticks + 1'b1;
        end else begin
            presc <= presc + 1'b1;
        end
    end

    // R6: window count only steps by one tick or restarts from a clear
    a_r6_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ticks) |-> ($past(clear) || ticks == $past(ticks) + 1'b1));
endmodule

// File: rtl/d0dg_seq.sv
module d0dg_seq
    import d0dg_pkg::*;
#(
    parameter int TICK_DIV       = 50000,
    parameter int PRES_TICKS     = 450,
    parameter int RELEASE_TICKS  = 1,
    parameter int RST_PASS_TICKS = 30000,
    parameter int CMD_PASS_TICKS = 5000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart_pls,
    input  logic       diag_cmd_pls,
    input  logic       self_done,
    input  logic [7:0] self_code,
    input  logic       dasp_n_in,
    input  logic       pdiag_n_in,
    output logic [7:0] err_code,
    output logic       busy,
    output logic       irq,
    output logic       d1_present
);
    localparam int M1     = (PRES_TICKS > RELEASE_TICKS) ? PRES_TICKS : RELEASE_TICKS;
    localparam int M2     = (RST_PASS_TICKS > CMD_PASS_TICKS) ? RST_PASS_TICKS : CMD_PASS_TICKS;
    localparam int MAXLIM = (M1 > M2) ? M1 : M2;
    localparam int CNT_W  = $clog2(MAXLIM + 2);

    localparam logic [CNT_W-1:0] LIM_PRES = CNT_W'(PRES_TICKS);
    localparam logic [CNT_W-1:0] LIM_REL  = CNT_W'(RELEASE_TICKS);
    localparam logic [CNT_W-1:0] LIM_RST  = CNT_W'(RST_PASS_TICKS);
    localparam logic [CNT_W-1:0] LIM_CMD  = CNT_W'(CMD_PASS_TICKS);

    d0dg_state_e state_q, state_d;
    logic present_d, fail_q, fail_d, fromrst_q, fromrst_d;
    logic own_done_q;
    logic [7:0] own_code_q;
    logic [1:0] lines_sync;
    logic dasp_seen, pdiag_seen;
    logic tmr_clr;
    logic [CNT_W-1:0] ticks;

    d0dg_sync #(.W(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in({pdiag_n_in, dasp_n_in}),
        .sync_out(lines_sync)
    );
    assign dasp_seen  = !lines_sync[0];
    assign pdiag_seen = !lines_sync[1];

    d0dg_win_timer #(.TICK_DIV(TICK_DIV), .CNT_W(CNT_W)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(tmr_clr),
        .ticks(ticks)
    );

    // Next-state logic
    always_comb begin
        state_d   = state_q;
        present_d = d1_present;
        fail_d    = fail_q;
        fromrst_d = fromrst_q;
        unique case (state_q)
            ST_IDLE: begin
                if (diag_cmd_pls) begin
                    fail_d    = 1'b0;
                    fromrst_d = 1'b0;
                    state_d   = d1_present ? ST_HOLDOFF : ST_SELFWAIT;
                end
            end
            ST_PRESENCE: begin
                if (dasp_seen) begin
                    present_d = 1'b1;
                    state_d   = ST_HOLDOFF;
                end else if (ticks >= LIM_PRES) begin
                    state_d = ST_SELFWAIT;
                end
            end
            ST_HOLDOFF: begin
                if (ticks >= LIM_REL) state_d = ST_PASSWAIT;
            end
            ST_PASSWAIT: begin
                if (pdiag_seen) begin
                    state_d = ST_SELFWAIT;
                end else if (ticks >= (fromrst_q ? LIM_RST : LIM_CMD)) begin
                    fail_d  = 1'b1;
                    state_d = ST_SELFWAIT;
                end
            end
            ST_SELFWAIT: begin
                if (own_done_q) state_d = ST_POST;
            end
            ST_POST: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
        if (restart_pls) begin
            state_d   = ST_PRESENCE;
            present_d = 1'b0;
            fail_d    = 1'b0;
            fromrst_d = 1'b1;
        end
    end

    assign tmr_clr = (state_d != state_q) || restart_pls;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            d1_present <= 1'b0;
            fail_q     <= 1'b0;
            fromrst_q  <= 1'b0;
        end else begin
            state_q    <= state_d;
            d1_present <= present_d;
            fail_q     <= fail_d;
            fromrst_q  <= fromrst_d;
        end
    end

    // Own self-test result latch and posted code
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            own_done_q <= 1'b0;
            own_code_q <= '0;
            err_code   <= '0;
        end else begin
            if (restart_pls || (state_q == ST_IDLE && diag_cmd_pls)) begin
                own_done_q <= 1'b0;
            end else if (self_done && busy) begin
                own_done_q <= 1'b1;
                own_code_q <= self_code;
            end
            if (state_q == ST_SELFWAIT && own_done_q && !restart_pls)
                err_code <= merge_code(fail_q, own_code_q);
        end
    end

    // Outputs
    always_comb begin
        busy = !(state_q inside {ST_IDLE, ST_POST});
        irq  = (state_q == ST_POST);
    end

    // R2: a reset request always leaves the block busy
    a_r2_restart_busy: assert property (@(posedge clk) disable iff (!rst_n)
        restart_pls |=> busy);
    // R4: an absent drive 1 never flags a failure
    a_r4_absent_no_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !d1_present) |-> !err_code[7]);
    // R9: interrupt lasts one cycle and is followed by idle
    a_r9_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> (!irq && !busy));
    // R9: the posted code only moves together with the interrupt
    a_r9_code_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(err_code) |-> irq);
    // R3: presence only changes inside a sequence or on a reset request
    a_r3_present_change: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(d1_present) |-> ($past(busy) || $past(restart_pls)));
endmodule

// File: tb/test_d0dg_seq.sv
module test_d0dg_seq;
    localparam int D    = 4;
    localparam int PRES = 20;
    localparam int REL  = 5;
    localparam int RSTW = 60;
    localparam int CMDW = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic restart_pls = 1'b0, diag_cmd_pls = 1'b0, self_done = 1'b0;
    logic [7:0] self_code = 8'h00;
    logic dasp_n_in = 1'b1, pdiag_n_in = 1'b1;
    logic [7:0] err_code;
    logic busy, irq, d1_present;

    always #10 clk = ~clk;

    d0dg_seq #(
        .TICK_DIV(D), .PRES_TICKS(PRES), .RELEASE_TICKS(REL),
        .RST_PASS_TICKS(RSTW), .CMD_PASS_TICKS(CMDW)
    ) i_d0dg_seq (
        .clk(clk), .rst_n(rst_n), .restart_pls(restart_pls), .diag_cmd_pls(diag_cmd_pls),
        .self_done(self_done), .self_code(self_code), .dasp_n_in(dasp_n_in),
        .pdiag_n_in(pdiag_n_in), .err_code(err_code), .busy(busy), .irq(irq),
        .d1_present(d1_present)
    );

    int nchk = 0, nfail = 0;
    bit prev_present = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_code(input bit fail, input int own);
        return {fail, 7'(own)};
    endfunction

    // inj: 0 none, 1 command pulse at cycle 5, 2 restart at cycle 30 with drive 1 gone
    task automatic run_seq(input bit is_reset, input bit d1_dasp, input bit d1_pass,
                           input int pass_delay, input int own, input int self_delay,
                           input int inj);
        int done_c = -1;
        bit busy_bad = 1'b0, busy_at_done = 1'b1, gone = 1'b0;
        bit eff_present, exp_fail;
        int lo, hi;
        logic [7:0] code_at_done;
        eff_present = (inj == 2) ? 1'b0 : (is_reset ? d1_dasp : prev_present);
        exp_fail    = eff_present && !d1_pass;
        pdiag_n_in = 1'b1;
        dasp_n_in  = 1'b1;
        @(negedge clk);
        if (is_reset) restart_pls = 1'b1; else diag_cmd_pls = 1'b1;
        for (int c = 1; c <= 900 && done_c < 0; c++) begin
            @(negedge clk);
            restart_pls = 1'b0; diag_cmd_pls = 1'b0; self_done = 1'b0;
            if (irq) begin
                done_c = c; busy_at_done = busy; code_at_done = err_code;
            end else if (!busy) busy_bad = 1'b1;
            if (inj == 2 && c >= 30) gone = 1'b1;
            if (inj == 2 && c == 30) restart_pls = 1'b1;
            if (inj == 1 && c == 5) diag_cmd_pls = 1'b1;
            dasp_n_in  = !(is_reset && d1_dasp && !gone && c >= 10);
            pdiag_n_in = !(d1_pass && !gone && c >= pass_delay);
            if (c == self_delay) begin self_done = 1'b1; self_code = 8'(own); end
        end
        restart_pls = 1'b0; diag_cmd_pls = 1'b0; self_done = 1'b0;
        if (inj == 2) begin lo = 30 + PRES * D; hi = lo + 20; end
        else if (is_reset && !eff_present) begin lo = PRES * D; hi = lo + 10; end
        else if (exp_fail) begin
            lo = (REL + (is_reset ? RSTW : CMDW)) * D + (is_reset ? 10 : 0);
            hi = lo + 20;
        end
        else if (!eff_present) begin lo = self_delay; hi = self_delay + 4; end
        else begin lo = self_delay; hi = 900; end

        chk(done_c > 0, "R9 completion seen", done_c, 1);
        chk(!busy_bad, "R2 busy held until completion", busy_bad, 0);
        chk(!busy_at_done, "R9 busy clear at irq", busy_at_done, 0);
        chk(d1_present == eff_present, (inj == 1) ? "R7 command ignored while busy" :
            (inj == 2) ? "R2 restart aborts" : (is_reset ? "R3 presence" : "R7 presence reused"),
            d1_present, eff_present);
        chk(code_at_done[7] == exp_fail, exp_fail ? "R6 fail flag" :
            (eff_present ? "R5 pass flag" : "R4 absent flag"), code_at_done[7], exp_fail);
        chk(code_at_done == exp_code(exp_fail, own), "R8 own code merge",
            code_at_done, exp_code(exp_fail, own));
        chk(done_c >= lo, exp_fail ? "R6 window not cut short" :
            (eff_present ? "R8 waits own result" : "R3 presence window length"), done_c, lo);
        chk(done_c <= hi, exp_fail ? "R6 window length" :
            (is_reset ? "R3 presence window length" : "R4 no pass wait when absent"), done_c, hi);
        @(negedge clk);
        chk(!irq && !busy, "R9 irq single cycle", {irq, busy}, 0);
        chk(err_code == code_at_done, "R9 code held", err_code, code_at_done);
        prev_present = eff_present;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int unsigned seed;
        bit r_reset, r_dasp, r_pass;
        int r_pd, r_own, r_sd;
        seed = 32'd2024;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !irq && err_code == 8'h00 && !d1_present, "R1 reset state",
            {busy, irq, d1_present, err_code}, 0);

        run_seq(1, 0, 0, 0,   1, 20, 0);   // R3 absent at reset, R4
        run_seq(0, 0, 0, 0,   2, 15, 0);   // R4 command path, no pass wait
        run_seq(1, 1, 1, 40,  2, 30, 0);   // R5 pass after reset
        run_seq(0, 1, 0, 0,   3, 25, 0);   // R6 command window fail
        run_seq(1, 1, 0, 0,   5, 40, 0);   // R6 reset window fail
        run_seq(0, 1, 0, 0,   4, 60, 2);   // R2 restart mid-sequence
        run_seq(1, 1, 1, 60,  1, 10, 1);   // R7 command ignored while busy
        run_seq(0, 1, 1, 5,   3, 3,  0);   // R5 pass line already low, R8 early result

        for (int k = 0; k < 40; k++) begin
            r_reset = 1'($urandom);
            r_dasp  = 1'($urandom);
            r_pass  = 1'($urandom);
            r_pd    = 5 + int'($urandom % 96);
            r_own   = 1 + int'($urandom % 5);
            r_sd    = 3 + int'($urandom % 48);
            run_seq(r_reset, r_dasp, r_pass, r_pd, r_own, r_sd, 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule